// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Port

The block collects up to 32 interrupt request lines, latches each one in a status bit, and masks the latched bits with a per-source enable. Any enabled, latched request drives a single interrupt line toward the processor, provided two gate bits in a master control register are both set. Software finds out which source to service by reading a vector register, which returns the index of the lowest-numbered pending source.

Each input is fixed at build time as edge type or level type through a parameter mask. A 1 in the mask selects edge type. An edge input latches on a rising edge and holds until software acknowledges it. A level input keeps re-latching on every cycle while the line stays high. Enable bits can be replaced as a whole word, or set and cleared bit by bit through two dedicated write-only addresses, so a driver never needs a read-modify-write.

Access is through a single-cycle register port. A write takes effect on the clock edge where the strobe is high. Read data is a combinational function of the address and the current state.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the registers at byte offsets 0x00 (status), 0x04 (pending), 0x08 (enable) and 0x1C (master) read zero, 0x18 (vector) reads 0xFFFFFFFF, and `cpu_irq` is low.
- R2: An edge-type input (its bit in `EDGE_MASK` is 1; the default mask 0x00000010 makes only input 4 edge type) sets its status bit on the edge after the input rises. The bit stays set after the input falls, and stays clear after an acknowledge while the input remains high.
- R3: A level-type input sets its status bit on every clock edge where the input is high. An acknowledge during that time leaves the bit set. Once the input is low, the bit stays latched until it is acknowledged.
- R4: A write to 0x0C clears exactly the status bits whose data bits are 1. Writing 0xFFFFFFFF clears every latched bit whose input is not still requesting.
- R5: A write to 0x08 replaces the whole enable register. A write to 0x10 sets only the enable bits given as 1 in the data, and a write to 0x14 clears only those bits. All other bits keep their values.
- R6: Reading 0x04 returns status AND enable.
- R7: In the register at 0x1C, bit 0 is the master enable and bit 1 is the hardware-output enable. `cpu_irq` is high exactly when both bits are 1 and at least one pending bit is 1.
- R8: Reading 0x18 returns the index of the lowest-numbered pending source, or 0xFFFFFFFF when nothing is pending.
- R9: Writes to the status, pending and vector offsets change no state. Reads of the write-only offsets 0x0C, 0x10 and 0x14 return zero.
- R10: Source n maps to bit n in status, pending, enable, acknowledge, set-enable and clear-enable, up to bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (5) | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe, one write per cycle where high |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr` |
| irq_in | input | NUM_SRC (32) | Interrupt request lines |
| cpu_irq | output | 1 | Combined interrupt line to the processor |

## Verification
The bench targets the difference between edge and level latching. An acknowledge while a level line is still high must not clear its bit, and an acknowledge while an edge line is still high must clear its bit for good. A design that mixed the two would either lose a held level request or raise a second interrupt for a single edge. It also checks that set-enable and clear-enable touch only the given bits, since a design that treated them as plain writes would silently drop other sources. It checks vector priority between two pending sources, the all-ones value when nothing is pending, and source 31 at the top bit, where a narrow encoder would return a wrong index. Each master gate bit is checked alone, because a design that used OR instead of AND for the gates would raise `cpu_irq` with only one of them set.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   // Byte offsets of the register port; software depends on these values.
   localparam logic [7:0] OFF_STATUS  = 8'h00;
   localparam logic [7:0] OFF_PENDING = 8'h04;
   localparam logic [7:0] OFF_ENABLE  = 8'h08;
   localparam logic [7:0] OFF_ACK     = 8'h0C;
   localparam logic [7:0] OFF_SETEN   = 8'h10;
   localparam logic [7:0] OFF_CLREN   = 8'h14;
   localparam logic [7:0] OFF_VECTOR  = 8'h18;
   localparam logic [7:0] OFF_MASTER  = 8'h1C;

   // Master register bit positions.
   localparam int MST_ME_BIT  = 0;
   localparam int MST_HIE_BIT = 1;
   localparam int MST_W       = 2;

   typedef struct packed {
      logic ack;
      logic en_all;
      logic en_set;
      logic en_clr;
      logic master;
   } wr_strobe_t;
endpackage

// File: rtl/irqc_src_cell.sv
module irqc_src_cell #(
   parameter bit IS_EDGE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic ack_clr,
   output logic flag_q
);
   logic set_now;

   generate
      if (IS_EDGE) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= req;
         end
         assign set_now = req & ~prev_q;
      end else begin : g_level
         assign set_now = req;
      end
   endgenerate

   // A new request in the same cycle wins over an acknowledge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= set_now | (flag_q & ~ack_clr);
   end
endmodule

// File: rtl/irqc_lowest_idx.sv
module irqc_lowest_idx #(
   parameter int N = 32,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/irqc_ctrl_regs.sv
module irqc_ctrl_regs
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wr_strobe_t        stb,
   input  logic [DATA_W-1:0] wdata,
   output logic [NUM_SRC-1:0] enable_q,
   output logic [MST_W-1:0]   master_q
);
   logic [NUM_SRC-1:0] mask;
   assign mask = wdata[NUM_SRC-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
      end else if (stb.en_all) begin
         enable_q <= mask;
      end else if (stb.en_set) begin
         enable_q <= enable_q | mask;
      end else if (stb.en_clr) begin
         enable_q <= enable_q & ~mask;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          master_q <= '0;
      else if (stb.master) master_q <= wdata[MST_W-1:0];
   end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irqc_pkg::*;
#(
   parameter int          NUM_SRC   = 32,
   parameter int          DATA_W    = 32,
   parameter int          ADDR_W    = 5,
   parameter logic [31:0] EDGE_MASK = 32'h0000_0010
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] irq_in,
   output logic               cpu_irq
);
   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   // Elaboration-time parameter checks.
   if (NUM_SRC < 1 || NUM_SRC > 32) begin : g_bad_src
      $error("NUM_SRC must lie in 1..32");
   end
   if (DATA_W < 32) begin : g_bad_data
      $error("DATA_W must be at least 32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must be at least 5");
   end

   logic [NUM_SRC-1:0] status_q;
   logic [NUM_SRC-1:0] enable_q;
   logic [MST_W-1:0]   master_q;
   logic [NUM_SRC-1:0] pending;
   logic [DATA_W-1:0]  vector_word;
   logic               vec_found;
   logic [IDX_W-1:0]   vec_idx;
   wr_strobe_t         stb;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
      return a == ADDR_W'(off);
   endfunction

   // Write decode.
   always_comb begin
      stb.ack    = bus_wr & hit(bus_addr, OFF_ACK);
      stb.en_all = bus_wr & hit(bus_addr, OFF_ENABLE);
      stb.en_set = bus_wr & hit(bus_addr, OFF_SETEN);
      stb.en_clr = bus_wr & hit(bus_addr, OFF_CLREN);
      stb.master = bus_wr & hit(bus_addr, OFF_MASTER);
   end

   // One latch cell per source; the type mask picks the variant.
   for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
      irqc_src_cell #(.IS_EDGE(EDGE_MASK[gi])) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .req     (irq_in[gi]),
         .ack_clr (stb.ack & bus_wdata[gi]),
         .flag_q  (status_q[gi])
      );
   end

   irqc_ctrl_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (stb),
      .wdata    (bus_wdata),
      .enable_q (enable_q),
      .master_q (master_q)
   );

   assign pending = status_q & enable_q;

   irqc_lowest_idx #(.N(NUM_SRC)) u_prio (
      .vec   (pending),
      .found (vec_found),
      .idx   (vec_idx)
   );

   assign vector_word = vec_found ? DATA_W'(vec_idx) : {DATA_W{1'b1}};

   assign cpu_irq = master_q[MST_ME_BIT] & master_q[MST_HIE_BIT] & (|pending);

   // Read mux; write-only locations read as zero.
   always_comb begin
      bus_rdata = '0;
      if (hit(bus_addr, OFF_STATUS))       bus_rdata = DATA_W'(status_q);
      else if (hit(bus_addr, OFF_PENDING)) bus_rdata = DATA_W'(pending);
      else if (hit(bus_addr, OFF_ENABLE))  bus_rdata = DATA_W'(enable_q);
      else if (hit(bus_addr, OFF_VECTOR))  bus_rdata = vector_word;
      else if (hit(bus_addr, OFF_MASTER))  bus_rdata = DATA_W'(master_q);
   end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
   import irqc_pkg::*;
#(
   parameter int          NUM_SRC   = 32,
   parameter int          DATA_W    = 32,
   parameter int          ADDR_W    = 5,
   parameter logic [31:0] EDGE_MASK = 32'h0000_0010
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_wr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [NUM_SRC-1:0] irq_in,
   input logic               cpu_irq,
   input logic [NUM_SRC-1:0] status_q,
   input logic [NUM_SRC-1:0] enable_q,
   input logic [MST_W-1:0]   master_q,
   input logic [DATA_W-1:0]  vector_word
);
   localparam logic [NUM_SRC-1:0] LVL = ~EDGE_MASK[NUM_SRC-1:0];

   logic ack_wr, set_wr, clr_wr;
   assign ack_wr = bus_wr && bus_addr == ADDR_W'(OFF_ACK);
   assign set_wr = bus_wr && bus_addr == ADDR_W'(OFF_SETEN);
   assign clr_wr = bus_wr && bus_addr == ADDR_W'(OFF_CLREN);

   // R2 / R4: without an acknowledge no latched bit is lost.
   p_hold_no_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_wr |=> (status_q & $past(status_q)) == $past(status_q));

   // R3: a high level input is latched on the next edge.
   p_level_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (status_q & $past(irq_in & LVL)) == $past(irq_in & LVL));

   // R5: set-enable only adds bits.
   p_set_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set_wr |=> enable_q == ($past(enable_q) | $past(bus_wdata[NUM_SRC-1:0])));

   // R5: clear-enable only removes bits.
   p_clr_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> enable_q == ($past(enable_q) & ~$past(bus_wdata[NUM_SRC-1:0])));

   // R7: the processor line needs both gates and a pending source.
   p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> (master_q == 2'b11) && ((status_q & enable_q) != '0));

   // R8: nothing pending gives the all-ones vector.
   p_vec_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q & enable_q) == '0) |-> vector_word == {DATA_W{1'b1}});
endmodule

bind irq_vector_ctrl irqc_checker #(
   .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EDGE_MASK(EDGE_MASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .irq_in(irq_in), .cpu_irq(cpu_irq),
   .status_q(status_q), .enable_q(enable_q), .master_q(master_q),
   .vector_word(vector_word)
);

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
   localparam int CLK_P = 10;

   localparam logic [4:0] A_STAT = 5'h00, A_PEND = 5'h04, A_EN = 5'h08,
                          A_ACK = 5'h0C, A_SET = 5'h10, A_CLR = 5'h14,
                          A_VEC = 5'h18, A_MST = 5'h1C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] irq_in = '0;
   logic        cpu_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   irq_vector_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
      .cpu_irq(cpu_irq)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // Inputs change just after a falling edge; the write lands on the next rising edge.
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic rdchk(input logic [4:0] a, input logic [31:0] exp, input string tag);
      logic [31:0] d;
      rd(a, d);
      chk(d, exp, tag);
   endtask

   // Drive a one-cycle pulse on the given lines.
   task automatic pulse(input logic [31:0] m);
      @(negedge clk); irq_in = irq_in | m;
      @(negedge clk); irq_in = irq_in & ~m;
   endtask

   task automatic t_reset;
      rdchk(A_STAT, 32'h0, "R1 status");
      rdchk(A_PEND, 32'h0, "R1 pending");
      rdchk(A_EN,   32'h0, "R1 enable");
      rdchk(A_MST,  32'h0, "R1 master");
      rdchk(A_VEC,  32'hFFFF_FFFF, "R1 vector");
      chk({31'b0, cpu_irq}, 32'h0, "R1 cpu_irq");
   endtask

   task automatic t_edge;
      @(negedge clk); irq_in[4] = 1'b1;
      @(negedge clk); rdchk(A_STAT, 32'h10, "R2 edge latch");
      irq_in[4] = 1'b0;
      @(negedge clk); rdchk(A_STAT, 32'h10, "R2 edge held after fall");
      wr(A_ACK, 32'h10);
      rdchk(A_STAT, 32'h0, "R4 ack clears edge bit");
      // Rise and stay high; acknowledge while high must clear for good.
      irq_in[4] = 1'b1;
      @(negedge clk); @(negedge clk);
      rdchk(A_STAT, 32'h10, "R2 edge latched once");
      wr(A_ACK, 32'h10);
      @(negedge clk); @(negedge clk);
      rdchk(A_STAT, 32'h0, "R2 no relatch while high");
      irq_in[4] = 1'b0;
   endtask

   task automatic t_level;
      @(negedge clk); irq_in[7] = 1'b1;
      @(negedge clk); rdchk(A_STAT, 32'h80, "R3 level latch");
      wr(A_ACK, 32'h80);
      rdchk(A_STAT, 32'h80, "R3 ack while high keeps bit");
      irq_in[7] = 1'b0;
      @(negedge clk); rdchk(A_STAT, 32'h80, "R3 latched after fall");
      wr(A_ACK, 32'h80);
      rdchk(A_STAT, 32'h0, "R3 ack after fall clears");
   endtask

   task automatic t_ack_all;
      pulse(32'h0000_0016);
      rdchk(A_STAT, 32'h16, "R4 three latched");
      wr(A_ACK, 32'h0000_0002);
      rdchk(A_STAT, 32'h14, "R4 single ack");
      wr(A_ACK, 32'hFFFF_FFFF);
      rdchk(A_STAT, 32'h0, "R4 ack all");
   endtask

   task automatic t_enable;
      wr(A_EN, 32'h0000_0F0F);
      rdchk(A_EN, 32'h0000_0F0F, "R5 direct write");
      wr(A_SET, 32'h0001_0000);
      rdchk(A_EN, 32'h0001_0F0F, "R5 set-enable");
      wr(A_CLR, 32'h0000_0003);
      rdchk(A_EN, 32'h0001_0F0C, "R5 clear-enable");
      wr(A_SET, 32'h8000_0000);
      rdchk(A_EN, 32'h8001_0F0C, "R10 set bit 31");
      wr(A_EN, 32'h0000_0005);
      rdchk(A_EN, 32'h0000_0005, "R5 direct replace");
      wr(A_EN, 32'h0);
   endtask

   task automatic t_pend_vec;
      pulse(32'h0000_0208);
      wr(A_EN, 32'h0000_0200);
      rdchk(A_PEND, 32'h0000_0200, "R6 pending masked");
      rdchk(A_VEC, 32'd9, "R8 vector single");
      wr(A_EN, 32'h0000_0208);
      rdchk(A_PEND, 32'h0000_0208, "R6 pending two");
      rdchk(A_VEC, 32'd3, "R8 vector lowest");
      wr(A_EN, 32'h0);
      rdchk(A_VEC, 32'hFFFF_FFFF, "R8 vector none");
      wr(A_ACK, 32'hFFFF_FFFF);
      pulse(32'h8000_0000);
      wr(A_EN, 32'h8000_0000);
      rdchk(A_VEC, 32'd31, "R10 vector source 31");
      rdchk(A_PEND, 32'h8000_0000, "R10 pending bit 31");
      wr(A_EN, 32'h0);
      wr(A_ACK, 32'hFFFF_FFFF);
   endtask

   task automatic t_master;
      pulse(32'h0000_0008);
      wr(A_EN, 32'h0000_0008);
      chk({31'b0, cpu_irq}, 32'h0, "R7 master off");
      wr(A_MST, 32'h1);
      chk({31'b0, cpu_irq}, 32'h0, "R7 only bit0");
      wr(A_MST, 32'h2);
      chk({31'b0, cpu_irq}, 32'h0, "R7 only bit1");
      wr(A_MST, 32'h3);
      chk({31'b0, cpu_irq}, 32'h1, "R7 both gates");
      rdchk(A_MST, 32'h3, "R7 master readback");
      wr(A_CLR, 32'h0000_0008);
      chk({31'b0, cpu_irq}, 32'h0, "R7 no pending");
      wr(A_ACK, 32'hFFFF_FFFF);
      wr(A_MST, 32'h0);
   endtask

   task automatic t_ignored;
      pulse(32'h0000_0020);
      wr(A_STAT, 32'h0);
      rdchk(A_STAT, 32'h20, "R9 status write ignored");
      wr(A_PEND, 32'hFFFF_FFFF);
      wr(A_VEC, 32'hFFFF_FFFF);
      rdchk(A_EN, 32'h0, "R9 enable untouched");
      rdchk(A_STAT, 32'h20, "R9 status untouched");
      rdchk(A_MST, 32'h0, "R9 master untouched");
      rdchk(A_ACK, 32'h0, "R9 ack reads zero");
      rdchk(A_SET, 32'h0, "R9 set reads zero");
      rdchk(A_CLR, 32'h0, "R9 clr reads zero");
      wr(A_ACK, 32'hFFFF_FFFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_edge();
      t_level();
      t_ack_all();
      t_enable();
      t_pend_vec();
      t_master();
      t_ignored();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule